// File: doc/BRIEF.md
# Oversampled Miller Pause Decoder

This block is the receive front end on the card side of a proximity link. It takes the demodulated reader signal, where a 1 means the carrier is paused, and returns a plain bit stream. The signal is sampled once per cycle in which `smp_en_i` is high. The parameter `OVS` sets 4 or 8 samples per bit period. On an idle line, the first pause sample fixes the bit grid: that sample becomes position 0 of the first bit window.

Each completed window of `OVS` samples is classified as one of three patterns by where its pause lies:

- pattern X: a pause in the middle of the period;
- pattern Z: a pause at the start of the period;
- pattern Y: no pause.

A small state machine turns the pattern stream into data bits. It marks the start and end of each frame with one-cycle pulses. It aborts the frame with an error pulse when a pause arrives in an unexpected place, or when the frame grows beyond `MAX_BITS` data bits. Checking parity and CRC, and assembling bytes, is left to the logic downstream.

Top module: `miller_pause_rx`

## Requirements
- R1: After reset, `bit_vld_o`, `sof_o`, `eof_o` and `err_o` are low and stay low while no pause is sampled.
- R2: While hunting, pause-free samples have no effect. The first sampled pause becomes position 0 of a new bit window, whatever the number of idle samples before it.
- R3: Sample positions 0 to OVS/4-1 form the early window. Positions OVS/2 to 3*OVS/4-1 form the middle window. A window with a pause only in the middle window is X, one with a pause only in the early window is Z, and one with no pause is Y. At OVS=8 a pause shifted by one sample (positions 1 or 5) is accepted.
- R4: The first window of a frame must be Z. It produces one `sof_o` pulse and no data bit.
- R5: X decodes to 1, Z decodes to 0, and Y following an X decodes to 0. Bits appear on `bit_o` with a `bit_vld_o` pulse, in arrival order. `bit_idx_o` is 0 for the first bit after SOF and rises by one for each following bit.
- R6: A Y that follows a Z, or follows a Y-coded 0, ends the frame with an `eof_o` pulse. The 0 just before that Y belongs to the end marker and is not output. SOF followed directly by Z then Y yields an empty frame.
- R7: A window with a pause in any position outside the early and middle windows, or with pauses in both of them, gives an `err_o` pulse. So does a first window that is not Z. The frame is abandoned: no `eof_o`, and the held-back bit is dropped.
- R8: A frame carries at most `MAX_BITS` data bits (default 2322). A frame of exactly `MAX_BITS` bits ends normally. When bit index `MAX_BITS` would be output, `err_o` pulses instead and the frame is abandoned.
- R9: `pause_i` is sampled only in cycles where `smp_en_i` is high. Its value in other cycles has no effect.
- R10: `bit_vld_o`, `sof_o`, `eof_o` and `err_o` are single-cycle pulses, and at most one of them is high in any cycle.
- R11: After `eof_o` or `err_o` the receiver hunts again, and the next pause starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| smp_en_i | input | 1 | Sample strobe, one per oversampling slot |
| pause_i | input | 1 | Demodulated line, 1 = carrier pause |
| bit_vld_o | output | 1 | Decoded data bit strobe |
| bit_o | output | 1 | Decoded data bit value |
| bit_idx_o | output | IDX_W | Index of the bit within its frame |
| sof_o | output | 1 | Start-of-frame pulse |
| eof_o | output | 1 | End-of-frame pulse |
| err_o | output | 1 | Frame error pulse |

## Verification
The bench builds two instances side by side, each driven on its own pause line:

- an 8-times-oversampled one with the default 2322-bit limit, which covers the one-sample phase tolerance, input noise between sample strobes, and the error placements possible in an 8-slot window;
- a 4-times-oversampled one with `MAX_BITS` set to 12, which brings both the exact-length frame and the over-length abort within a few dozen bit periods.

Frames are produced by an encoder in the bench. That encoder follows the pattern rules from the transmit side, so the decoded bits are compared against the data the encoder was given.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

  // Classification of one completed bit window.
  typedef enum logic [1:0] {
    SYM_Y   = 2'd0,
    SYM_X   = 2'd1,
    SYM_Z   = 2'd2,
    SYM_BAD = 2'd3
  } sym_e;

  // Decoder state: hunting, or which pattern was decoded last.
  typedef enum logic [1:0] {
    ST_HUNT   = 2'd0,
    ST_AFT_Z  = 2'd1,
    ST_AFT_X  = 2'd2,
    ST_AFT_Y0 = 2'd3
  } dec_st_e;

endpackage

// File: rtl/mpr_sampler.sv
module mpr_sampler #(
  parameter int unsigned OVS = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_en,
  input  logic           pause_i,
  input  logic           stop_i,
  output logic           win_vld_o,
  output logic [OVS-1:0] win_o
);

  localparam int unsigned PW = (OVS < 2) ? 1 : $clog2(OVS);
  localparam logic [PW-1:0] POS_LAST = PW'(OVS - 1);

  logic           run_q, run_d;
  logic [PW-1:0]  pos_q, pos_d;
  logic [OVS-1:0] acc_q, acc_d;
  logic [OVS-1:0] win_q, win_d;
  logic           vld_q, vld_d;
  logic           hunting;

  // A stop from the decoder takes effect in the same cycle, so a sample
  // arriving with it is already treated as a hunting sample.
  assign hunting = !run_q || stop_i;

  always_comb begin
    run_d = run_q;
    pos_d = pos_q;
    acc_d = acc_q;
    win_d = win_q;
    vld_d = 1'b0;
    if (stop_i) begin
      run_d = 1'b0;
      pos_d = '0;
      acc_d = '0;
    end
    if (smp_en) begin
      if (hunting) begin
        if (pause_i) begin
          run_d = 1'b1;
          pos_d = PW'(1);
          acc_d = {{(OVS-1){1'b0}}, 1'b1};
        end
      end else begin
        acc_d[pos_q] = pause_i;
        if (pos_q == POS_LAST) begin
          win_d = acc_d;
          vld_d = 1'b1;
          acc_d = '0;
          pos_d = '0;
        end else begin
          pos_d = pos_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      pos_q <= '0;
      acc_q <= '0;
      win_q <= '0;
      vld_q <= 1'b0;
    end else begin
      run_q <= run_d;
      pos_q <= pos_d;
      acc_q <= acc_d;
      win_q <= win_d;
      vld_q <= vld_d;
    end
  end

  assign win_vld_o = vld_q;
  assign win_o     = win_q;

  // A window needs OVS samples, so two completions are never adjacent.
  AST_WIN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q); // R3

endmodule

// File: rtl/mpr_classify.sv
module mpr_classify
  import mpr_pkg::*;
#(
  parameter int unsigned OVS = 8
) (
  input  logic [OVS-1:0] win_i,
  output sym_e           sym_o
);

  localparam int unsigned EW     = OVS / 4;
  localparam int unsigned MID_LO = OVS / 2;

  logic [OVS-1:0] early_m;
  logic [OVS-1:0] mid_m;
  logic           hit_e, hit_m, hit_g;

  for (genvar i = 0; i < OVS; i++) begin : g_mask
    assign early_m[i] = (i < EW);
    assign mid_m[i]   = (i >= MID_LO) && (i < MID_LO + EW);
  end

  assign hit_e = |(win_i & early_m);
  assign hit_m = |(win_i & mid_m);
  assign hit_g = |(win_i & ~(early_m | mid_m));

  always_comb begin
    if (hit_g || (hit_e && hit_m)) sym_o = SYM_BAD;
    else if (hit_e)                sym_o = SYM_Z;
    else if (hit_m)                sym_o = SYM_X;
    else                           sym_o = SYM_Y;
  end

endmodule

// File: rtl/mpr_decoder.sv
module mpr_decoder
  import mpr_pkg::*;
#(
  parameter int unsigned MAX_BITS = 2322,
  localparam int unsigned IW = (MAX_BITS < 2) ? 1 : $clog2(MAX_BITS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          win_vld_i,
  input  sym_e          sym_i,
  output logic          stop_o,
  output logic          bit_vld_o,
  output logic          bit_o,
  output logic [IW-1:0] bit_idx_o,
  output logic          sof_o,
  output logic          eof_o,
  output logic          err_o
);

  localparam int unsigned CW = $clog2(MAX_BITS + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MAX_BITS);

  dec_st_e       st_q, st_d;
  logic          pend_vld_q, pend_vld_d;
  logic          pend_q, pend_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          bv_q, bv_d;
  logic          b_q, b_d;
  logic [IW-1:0] idx_q, idx_d;
  logic          sof_q, sof_d;
  logic          eof_q, eof_d;
  logic          err_q, err_d;
  logic          do_push, push_val;
  logic          stop;

  always_comb begin
    st_d       = st_q;
    pend_vld_d = pend_vld_q;
    pend_d     = pend_q;
    cnt_d      = cnt_q;
    bv_d       = 1'b0;
    b_d        = b_q;
    idx_d      = idx_q;
    sof_d      = 1'b0;
    eof_d      = 1'b0;
    err_d      = 1'b0;
    stop       = 1'b0;
    do_push    = 1'b0;
    push_val   = 1'b0;

    if (win_vld_i) begin
      if (st_q == ST_HUNT) begin
        if (sym_i == SYM_Z) begin
          sof_d      = 1'b1;
          st_d       = ST_AFT_Z;
          pend_vld_d = 1'b0;
          cnt_d      = '0;
        end else begin
          err_d = 1'b1;
          stop  = 1'b1;
        end
      end else begin
        unique case (sym_i)
          SYM_X: begin
            do_push  = 1'b1;
            push_val = 1'b1;
            st_d     = ST_AFT_X;
          end
          SYM_Z: begin
            do_push  = 1'b1;
            push_val = 1'b0;
            st_d     = ST_AFT_Z;
          end
          SYM_Y: begin
            if (st_q == ST_AFT_X) begin
              do_push  = 1'b1;
              push_val = 1'b0;
              st_d     = ST_AFT_Y0;
            end else begin
              // End marker: the held-back 0 is part of it and is dropped.
              eof_d      = 1'b1;
              stop       = 1'b1;
              st_d       = ST_HUNT;
              pend_vld_d = 1'b0;
            end
          end
          default: begin
            err_d      = 1'b1;
            stop       = 1'b1;
            st_d       = ST_HUNT;
            pend_vld_d = 1'b0;
          end
        endcase
      end
    end

    // One bit is held back until the next pattern proves it is data.
    if (do_push) begin
      if (pend_vld_q) begin
        if (cnt_q == CNT_MAX) begin
          err_d      = 1'b1;
          stop       = 1'b1;
          st_d       = ST_HUNT;
          pend_vld_d = 1'b0;
        end else begin
          bv_d   = 1'b1;
          b_d    = pend_q;
          idx_d  = cnt_q[IW-1:0];
          cnt_d  = cnt_q + 1'b1;
          pend_d = push_val;
        end
      end else begin
        pend_vld_d = 1'b1;
        pend_d     = push_val;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_HUNT;
      pend_vld_q <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      bv_q       <= 1'b0;
      b_q        <= 1'b0;
      idx_q      <= '0;
      sof_q      <= 1'b0;
      eof_q      <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      st_q       <= st_d;
      pend_vld_q <= pend_vld_d;
      pend_q     <= pend_d;
      cnt_q      <= cnt_d;
      bv_q       <= bv_d;
      b_q        <= b_d;
      idx_q      <= idx_d;
      sof_q      <= sof_d;
      eof_q      <= eof_d;
      err_q      <= err_d;
    end
  end

  assign stop_o    = stop;
  assign bit_vld_o = bv_q;
  assign bit_o     = b_q;
  assign bit_idx_o = idx_q;
  assign sof_o     = sof_q;
  assign eof_o     = eof_q;
  assign err_o     = err_q;

  AST_EVT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bv_q, sof_q, eof_q, err_q})); // R10

  AST_SOF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    sof_q |=> !sof_q); // R10

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    bv_q |-> (int'(idx_q) < int'(MAX_BITS))); // R8

endmodule

// File: rtl/miller_pause_rx.sv
module miller_pause_rx
  import mpr_pkg::*;
#(
  parameter int unsigned OVS      = 8,
  parameter int unsigned MAX_BITS = 2322,
  localparam int unsigned IDX_W   = (MAX_BITS < 2) ? 1 : $clog2(MAX_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_en_i,
  input  logic             pause_i,
  output logic             bit_vld_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] bit_idx_o,
  output logic             sof_o,
  output logic             eof_o,
  output logic             err_o
);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           win_vld;
  logic [OVS-1:0] win;
  sym_e           sym;
  logic           stop;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mpr_sampler #(.OVS(OVS)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .smp_en    (smp_en_i),
    .pause_i   (pause_i),
    .stop_i    (stop),
    .win_vld_o (win_vld),
    .win_o     (win)
  );

  mpr_classify #(.OVS(OVS)) u_classify (
    .win_i (win),
    .sym_o (sym)
  );

  mpr_decoder #(.MAX_BITS(MAX_BITS)) u_decoder (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .win_vld_i (win_vld),
    .sym_i     (sym),
    .stop_o    (stop),
    .bit_vld_o (bit_vld_o),
    .bit_o     (bit_o),
    .bit_idx_o (bit_idx_o),
    .sof_o     (sof_o),
    .eof_o     (eof_o),
    .err_o     (err_o)
  );

  // Port-level frame tracking used only by the checks below.
  logic             open_q;
  logic             seen_q;
  logic [IDX_W-1:0] last_idx_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      open_q     <= 1'b0;
      seen_q     <= 1'b0;
      last_idx_q <= '0;
    end else begin
      if (sof_o)               open_q <= 1'b1;
      else if (eof_o || err_o) open_q <= 1'b0;
      if (sof_o)          seen_q <= 1'b0;
      else if (bit_vld_o) seen_q <= 1'b1;
      if (bit_vld_o) last_idx_q <= bit_idx_o;
    end
  end

  AST_BIT_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bit_vld_o || eof_o) |-> open_q); // R4

  AST_FIRST_IDX: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bit_vld_o && !seen_q) |-> (bit_idx_o == '0)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bit_vld_o && seen_q) |-> (bit_idx_o == last_idx_q + 1'b1)); // R5

endmodule

// File: tb/miller_pause_rx_tb.sv
module miller_pause_rx_tb_top;

  logic clk;
  logic rst_n;
  logic smp_en;
  logic p8, p4;
  logic sel;    // 0: 8x instance, 1: 4x instance
  logic noise;

  logic        bv8, b8, sof8, eof8, err8;
  logic [11:0] idx8;
  logic        bv4, b4, sof4, eof4, err4;
  logic [3:0]  idx4;

  int checks, errors;
  bit done;

  miller_pause_rx #(.OVS(8), .MAX_BITS(2322)) dut_i (
    .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en), .pause_i(p8),
    .bit_vld_o(bv8), .bit_o(b8), .bit_idx_o(idx8),
    .sof_o(sof8), .eof_o(eof8), .err_o(err8));

  miller_pause_rx #(.OVS(4), .MAX_BITS(12)) dut4_i (
    .clk(clk), .rst_n(rst_n), .smp_en_i(smp_en), .pause_i(p4),
    .bit_vld_o(bv4), .bit_o(b4), .bit_idx_o(idx4),
    .sof_o(sof4), .eof_o(eof4), .err_o(err4));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Event log for the selected instance
  logic got_bits [0:63];
  logic tx_bits  [0:63];
  int nbits, nsof, neof, nerr, multi, idx_bad;

  always @(negedge clk) begin
    if (rst_n) begin
      logic m_bv, m_b, m_sof, m_eof, m_err;
      int   m_idx;
      m_bv  = sel ? bv4  : bv8;
      m_b   = sel ? b4   : b8;
      m_sof = sel ? sof4 : sof8;
      m_eof = sel ? eof4 : eof8;
      m_err = sel ? err4 : err8;
      m_idx = sel ? int'(idx4) : int'(idx8);
      if ((int'(m_bv) + int'(m_sof) + int'(m_eof) + int'(m_err)) > 1) multi++;
      if (m_sof) nsof++;
      if (m_eof) neof++;
      if (m_err) nerr++;
      if (m_bv) begin
        if (m_idx != nbits) idx_bad++;
        if (nbits < 64) got_bits[nbits] = m_b;
        nbits++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_log();
    nbits = 0; nsof = 0; neof = 0; nerr = 0;
  endtask

  function automatic int ovs();
    return sel ? 4 : 8;
  endfunction

  task automatic put_sample(input logic v);
    @(negedge clk);
    if (sel) p4 = v; else p8 = v;
    smp_en = 1'b1;
    @(negedge clk);
    smp_en = 1'b0;
    if (sel) p4 = noise; else p8 = noise;
  endtask

  // kind: 0 = Y, 1 = X, 2 = Z; shift moves the pause by that many samples
  task automatic put_sym(input int kind, input int shift);
    for (int p = 0; p < ovs(); p++)
      put_sample((kind == 1 && p == ovs()/2 + shift) || (kind == 2 && p == shift));
  endtask

  // pattern written with sample position 0 as the leftmost of ovs() bits
  task automatic put_raw(input logic [7:0] pat);
    for (int p = 0; p < ovs(); p++) put_sample(pat[ovs()-1-p]);
  endtask

  task automatic idle_tail();
    for (int k = 0; k < 2*ovs(); k++) put_sample(1'b0);
    repeat (6) @(negedge clk);
  endtask

  // Transmit-side encoder: SOF, data, end marker (a 0 then Y)
  task automatic send_frame(input int n, input int shift);
    bit prev0;
    put_sym(2, 0);
    prev0 = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (tx_bits[i]) begin put_sym(1, shift); prev0 = 1'b0; end
      else begin put_sym(prev0 ? 2 : 0, shift); prev0 = 1'b1; end
    end
    put_sym(prev0 ? 2 : 0, shift);
    put_sym(0, shift);
    idle_tail();
  endtask

  task automatic check_frame(input string req, input int n, input int esof,
                             input int eeof, input int eerr);
    int ok_bits;
    chk(nsof == esof, req, "sof count", nsof, esof);
    chk(neof == eeof, req, "eof count", neof, eeof);
    chk(nerr == eerr, req, "err count", nerr, eerr);
    chk(nbits == n, req, "bit count", nbits, n);
    ok_bits = 1;
    for (int i = 0; i < n && i < nbits && i < 64; i++)
      if (got_bits[i] !== tx_bits[i]) ok_bits = 0;
    chk(ok_bits == 1, req, "bit values match", ok_bits, 1);
  endtask

  task automatic set_bits(input logic [15:0] v, input int n);
    for (int i = 0; i < n; i++) tx_bits[i] = v[i];
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    @(negedge clk);
    chk({bv8, sof8, eof8, err8, bv4, sof4, eof4, err4} == 8'd0, "R1",
        "strobes after reset", int'({bv8, sof8, eof8, err8, bv4, sof4, eof4, err4}), 0);
  endtask

  task automatic t_idle();
    sel = 0; clear_log();
    for (int k = 0; k < 23; k++) put_sample(1'b0);
    repeat (4) @(negedge clk);
    chk(nsof + neof + nerr + nbits == 0, "R2", "events on idle line",
        nsof + neof + nerr + nbits, 0);
  endtask

  task automatic t_short_frame();  // 7 bits, LSB first of 0x26; follows 23 idle samples (R2)
    sel = 0; clear_log();
    set_bits(16'h0026, 7);
    send_frame(7, 0);
    check_frame("R5", 7, 1, 1, 0);
  endtask

  task automatic t_shifted();      // R3: one-sample late pauses at 8x
    sel = 0; clear_log();
    set_bits(16'b110001, 6);       // bits 1,0,0,0,1,1 (ends on 1)
    send_frame(6, 1);
    check_frame("R3", 6, 1, 1, 0);
  endtask

  task automatic t_noise();        // R9: pause high between strobes
    sel = 0; clear_log(); noise = 1'b1;
    set_bits(16'b10100, 5);        // 0,0,1,0,1
    send_frame(5, 0);
    noise = 1'b0; p8 = 1'b0;
    check_frame("R9", 5, 1, 1, 0);
  endtask

  task automatic t_empty();        // R6: SOF, Z, Y
    sel = 0; clear_log();
    send_frame(0, 0);
    check_frame("R6", 0, 1, 1, 0);
  endtask

  task automatic t_guard_err();    // R7: pause in slot 2 of 8
    sel = 0; clear_log();
    put_sym(2, 0); put_sym(1, 0); put_sym(2, 0); put_sym(1, 0);
    put_raw(8'b0010_0000);
    idle_tail();
    tx_bits[0] = 1'b1; tx_bits[1] = 1'b0;
    check_frame("R7", 2, 1, 0, 1);
  endtask

  task automatic t_first_not_z();  // R7/R4: first window has both pauses
    sel = 0; clear_log();
    put_raw(8'b1000_1000);
    idle_tail();
    chk(nsof == 0, "R4", "no sof on bad first window", nsof, 0);
    chk(nerr == 1, "R7", "err on bad first window", nerr, 1);
  endtask

  task automatic t_4x_errors();    // R7 at 4x
    sel = 1; clear_log();
    put_sym(2, 0); put_raw(8'b0000_1010);
    idle_tail();
    chk(nerr == 1 && neof == 0 && nbits == 0, "R7", "early+middle pause err",
        nerr, 1);
    clear_log();
    put_sym(2, 0); put_raw(8'b0000_0100);
    idle_tail();
    chk(nerr == 1 && neof == 0 && nbits == 0, "R7", "guard slot pause err",
        nerr, 1);
  endtask

  task automatic t_4x_recover();   // R11: frame after errors
    sel = 1; clear_log();
    set_bits(16'b001011, 6);       // 1,1,0,1,0,0
    send_frame(6, 0);
    check_frame("R11", 6, 1, 1, 0);
  endtask

  task automatic t_4x_len();       // R8: limit 12
    sel = 1; clear_log();
    set_bits(16'hFFFF, 12);
    send_frame(12, 0);
    check_frame("R8", 12, 1, 1, 0);
    clear_log();
    set_bits(16'hFFFF, 14);
    send_frame(14, 0);
    check_frame("R8", 12, 1, 0, 1);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    multi = 0; idx_bad = 0;
    sel = 1'b0; noise = 1'b0;
    smp_en = 1'b0; p8 = 1'b0; p4 = 1'b0;
    clear_log();
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_idle();
    t_short_frame();
    t_shifted();
    t_noise();
    t_empty();
    t_guard_err();
    t_first_not_z();
    t_4x_errors();
    t_4x_recover();
    t_4x_len();
    chk(multi == 0, "R10", "cycles with more than one event", multi, 0);
    chk(idx_bad == 0, "R5", "bit index mismatches", idx_bad, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule